// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits in a receive path between a byte-level frame deframer and the write port of a receive FIFO. The deframer hands it one byte per valid cycle, with markers for the first and last byte of each frame. The first byte of a frame is its address. The filter compares that address with a programmable 8-bit match value and decides once, on that byte, whether the whole frame is kept.

A kept frame has its address byte, its control byte and every data byte written to the FIFO. Each write carries the end-of-frame flag on the last byte. A rejected frame produces no writes at all, and the filter goes back to waiting for the next frame start. An address of all ones is a broadcast and is always kept. When address matching is switched off, every frame is kept.

A small configuration port loads the matching enable and the match value in one write. The match value has no reset value, so software loads it before it turns matching on. It may be rewritten while frames are arriving. Because the decision is latched on the address byte, a rewrite only affects later frames. Dropping the receiver enable, or pulsing abort, ends the current frame immediately.

Top module: `faf_top`

## Requirements
- R1: After reset the filter is idle, matching is disabled and `fifo_we` is low.
- R2: A frame whose address equals the match value, with matching enabled, has every byte (address, control, data) written in arrival order. Each byte gives exactly one `fifo_we` pulse, on the cycle after the byte is presented.
- R3: A frame whose address differs from the match value, with matching enabled and the address not 0xFF, produces no `fifo_we` pulse for any of its bytes.
- R4: An address byte of 0xFF is accepted whatever the match value holds.
- R5: With matching disabled (`cfg_filt_en` written as 0), every frame is written in full whatever its address.
- R6: The accept decision uses the enable and match value held before the address byte's clock edge. A configuration write on that same edge, or later within the frame, changes only later frames.
- R7: `fifo_eof` is 1 exactly on the write of a frame's last byte, that is the byte presented with `in_eof`=1. A one-byte frame, with `in_sof` and `in_eof` both 1, is written as a single byte with `fifo_eof`=1.
- R8: When `abort_i` is 1 or `rx_en` is 0, the filter returns to idle and that cycle's byte is not written. Later bytes of the interrupted frame are not written.
- R9: Bytes that arrive while idle without `in_sof`=1 are not written.
- R10: Cycles with `in_vld`=0 write nothing. Gaps inside a frame do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; 0 forces idle and blocks all writes |
| abort_i | input | 1 | Frame abort from the deframer |
| in_vld | input | 1 | Byte valid |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first (address) byte of a frame |
| in_eof | input | 1 | Byte is the last byte of a frame |
| cfg_we | input | 1 | Loads both configuration fields |
| cfg_filt_en | input | 1 | Address matching enable to load |
| cfg_match | input | 8 | Match value to load |
| fifo_we | output | 1 | FIFO write strobe, one cycle per kept byte |
| fifo_data | output | 8 | Byte to write |
| fifo_eof | output | 1 | Marks the last byte of a frame |

## Verification
The critical coincidence is a configuration write on the same clock edge as a frame's address byte. The decision must use the old enable and match value, and the new ones must apply from the next frame on. The bench provokes this by driving `cfg_we` together with the address byte in both directions: from a matching value to a non-matching one, and from matching disabled to enabled. It judges the result from the FIFO writes of that frame and of the frame that follows. A second coincidence is an abort presented with a byte of a kept frame, including its end byte. That byte must not be written, and the frame's remaining bytes must not reach the FIFO.

// File: rtl/faf_pkg.sv
package faf_pkg;
  localparam int unsigned FAF_DW = 8;

  typedef enum logic [1:0] {
    FAF_IDLE = 2'd0,
    FAF_PASS = 2'd1,
    FAF_DROP = 2'd2
  } faf_state_e;

  // Keep decision for an address byte.
  function automatic logic faf_keep(input logic filt_en,
                                    input logic [FAF_DW-1:0] addr,
                                    input logic [FAF_DW-1:0] match);
    logic bcast;
    bcast = &addr;
    return (!filt_en) || bcast || (addr == match);
  endfunction
endpackage

// File: rtl/faf_cfg.sv
module faf_cfg
  import faf_pkg::*;
#(
  parameter int unsigned DW = FAF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          wr_en_bit,
  input  logic [DW-1:0] wr_match,
  output logic          filt_en,
  output logic [DW-1:0] match_val
);
  always_ff @(posedge clk) begin
    if (!rst_n) filt_en <= 1'b0;
    else if (wr) filt_en <= wr_en_bit;
  end

  // Match value deliberately has no reset: software loads it first.
  always_ff @(posedge clk) begin
    if (wr) match_val <= wr_match;
  end
endmodule

// File: rtl/faf_ctrl.sv
module faf_ctrl
  import faf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kill,
  input  logic       vld,
  input  logic       sof,
  input  logic       eof,
  input  logic       hit,
  output faf_state_e st,
  output logic       accept
);
  faf_state_e st_nx;

  always_comb begin
    st_nx  = st;
    accept = 1'b0;
    if (kill) begin
      st_nx = FAF_IDLE;
    end else begin
      unique case (st)
        FAF_IDLE: if (vld && sof) begin
          accept = hit;
          if (!eof) st_nx = hit ? FAF_PASS : FAF_DROP;
        end
        FAF_PASS: if (vld) begin
          accept = 1'b1;
          if (eof) st_nx = FAF_IDLE;
        end
        FAF_DROP: if (vld && eof) st_nx = FAF_IDLE;
        default: st_nx = FAF_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= FAF_IDLE;
    else st <= st_nx;
  end
endmodule

// File: rtl/faf_wr.sv
module faf_wr
  import faf_pkg::*;
#(
  parameter int unsigned DW = FAF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] data,
  input  logic          eof,
  output logic          we,
  output logic [DW-1:0] wdata,
  output logic          weof
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we    <= 1'b0;
      wdata <= '0;
      weof  <= 1'b0;
    end else begin
      we <= accept;
      if (accept) begin
        wdata <= data;
        weof  <= eof;
      end else begin
        weof  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/faf_top.sv
module faf_top
  import faf_pkg::*;
#(
  parameter int unsigned DW = FAF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          abort_i,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          cfg_we,
  input  logic          cfg_filt_en,
  input  logic [DW-1:0] cfg_match,
  output logic          fifo_we,
  output logic [DW-1:0] fifo_data,
  output logic          fifo_eof
);
  logic          filt_en;
  logic [DW-1:0] match_val;
  logic          evt_kill;
  logic          evt_hit;
  logic          evt_accept;
  faf_state_e    st;

  assign evt_kill = abort_i || !rx_en;
  assign evt_hit  = faf_keep(filt_en, in_data, match_val);

  faf_cfg #(.DW(DW)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr(cfg_we), .wr_en_bit(cfg_filt_en),
    .wr_match(cfg_match), .filt_en(filt_en), .match_val(match_val)
  );

  faf_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .kill(evt_kill), .vld(in_vld), .sof(in_sof),
    .eof(in_eof), .hit(evt_hit), .st(st), .accept(evt_accept)
  );

  faf_wr #(.DW(DW)) wr_i (
    .clk(clk), .rst_n(rst_n), .accept(evt_accept), .data(in_data),
    .eof(in_eof), .we(fifo_we), .wdata(fifo_data), .weof(fifo_eof)
  );
endmodule

// File: rtl/faf_chk.sv
module faf_chk
  import faf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       abort_i,
  input logic       in_vld,
  input logic [7:0] in_data,
  input logic       in_sof,
  input logic       fifo_we,
  input logic       fifo_eof,
  input faf_state_e st
);
  // R10: every write stems from a valid byte one cycle earlier
  a_r10_we_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(in_vld));

  // R8: abort or disable forces idle and blocks the next write
  a_r8_kill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i || !rx_en) |=> (st == FAF_IDLE && !fifo_we));

  // R3: nothing is written while a frame is being dropped
  a_r3_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FAF_DROP) |=> !fifo_we);

  // R4: broadcast address always accepted
  a_r4_bcast_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FAF_IDLE && in_vld && in_sof && rx_en && !abort_i && in_data == 8'hFF)
      |=> fifo_we);

  // R7: end-of-frame write leaves the filter idle
  a_r7_eof_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && fifo_eof) |-> (st == FAF_IDLE));

  // R9: a byte without start marker while idle is not written
  a_r9_idle_no_sof: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FAF_IDLE && !in_sof) |=> !fifo_we);
endmodule

bind faf_top faf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .abort_i(abort_i),
  .in_vld(in_vld), .in_data(in_data), .in_sof(in_sof),
  .fifo_we(fifo_we), .fifo_eof(fifo_eof), .st(st)
);

// File: tb/faf_top_tb.sv
module faf_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, abort_i = 1'b0, in_vld = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic       cfg_we = 1'b0, cfg_filt_en = 1'b0;
  logic [7:0] cfg_match = '0;
  logic       fifo_we, fifo_eof;
  logic [7:0] fifo_data;

  int n_chk = 0;
  int n_fail = 0;

  // bench-side model state
  logic       m_en = 1'b0;
  logic [7:0] m_match = '0;
  int         m_mode = 0; // 0 waiting, 1 keeping, 2 dropping
  logic [8:0] exp_q[$];
  string      req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  faf_top dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .abort_i(abort_i),
    .in_vld(in_vld), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .cfg_we(cfg_we), .cfg_filt_en(cfg_filt_en), .cfg_match(cfg_match),
    .fifo_we(fifo_we), .fifo_data(fifo_data), .fifo_eof(fifo_eof)
  );

  task automatic fail_msg(input string req, input string what, input int act, input int exp);
    n_fail++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && fifo_we) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        fail_msg("R3", "unexpected write", {fifo_eof, fifo_data}, 0);
      end else begin
        logic [8:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if ({fifo_eof, fifo_data} !== e) fail_msg(r, "write data/eof", {fifo_eof, fifo_data}, e);
      end
    end
  end

  // one cycle of stimulus plus bench-side expectation
  task automatic step(input logic vld, input logic [7:0] d, input logic sof, input logic eof,
                      input logic ab, input logic en, input logic cw, input logic cen,
                      input logic [7:0] cm, input string req);
    bit keep;
    @(negedge clk);
    in_vld = vld; in_data = d; in_sof = sof; in_eof = eof; abort_i = ab; rx_en = en;
    cfg_we = cw; cfg_filt_en = cen; cfg_match = cm;
    @(posedge clk); #1;
    if (ab || !en) begin
      m_mode = 0;
    end else if (vld) begin
      if (m_mode == 0 && sof) begin
        keep = (m_en == 1'b0) || (d == 8'hFF) || (d == m_match);
        if (keep) begin exp_q.push_back({eof, d}); req_q.push_back(req); end
        m_mode = eof ? 0 : (keep ? 1 : 2);
      end else if (m_mode == 1) begin
        exp_q.push_back({eof, d}); req_q.push_back(req);
        if (eof) m_mode = 0;
      end else if (m_mode == 2) begin
        if (eof) m_mode = 0;
      end
    end
    if (cw) begin m_en = cen; m_match = cm; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 1, 0, 0, 0, "R10");
  endtask

  task automatic cfg(input logic en, input logic [7:0] m);
    step(0, 8'h00, 0, 0, 0, 1, 1, en, m, "R6");
  endtask

  task automatic drain(input string req);
    idle(2);
    n_chk++;
    if (exp_q.size() != 0) begin
      fail_msg(req, "missing writes", 0, exp_q.size());
      exp_q.delete(); req_q.delete();
    end
  endtask

  // address, control, n data bytes; last carries eof
  task automatic frame(input logic [7:0] a, input int nd, input string req);
    step(1, a, 1, 0, 0, 1, 0, 0, 0, req);
    step(1, a ^ 8'h3C, 0, nd == 0, 0, 1, 0, 0, 0, req);
    for (int i = 0; i < nd; i++) step(1, 8'(a + i + 1), 0, i == nd - 1, 0, 1, 0, 0, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fail_msg("ALL", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (fifo_we !== 1'b0) fail_msg("R1", "fifo_we in reset", fifo_we, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (fifo_we !== 1'b0 || fifo_eof !== 1'b0) fail_msg("R1", "idle after reset", fifo_we, 0);

    // R1/R5: reset leaves matching off, so any address passes
    cfg_match = 8'h11;
    frame(8'h42, 1, "R1"); drain("R1");

    // R5: matching disabled, sweep every address
    cfg(0, 8'h5A);
    for (int a = 0; a < 256; a++) begin frame(8'(a), 1, "R5"); drain("R5"); end

    // R2/R3/R4: matching enabled, sweep every address against 0x5A
    cfg(1, 8'h5A);
    for (int a = 0; a < 256; a++) begin
      frame(8'(a), 1, (a == 8'h5A) ? "R2" : ((a == 8'hFF) ? "R4" : "R3"));
      drain("R3");
    end

    // R2/R4: sweep match values, exact address and broadcast
    for (int m = 0; m < 256; m += 17) begin
      cfg(1, 8'(m));
      frame(8'(m), 3, "R2"); drain("R2");
      frame(8'hFF, 2, "R4"); drain("R4");
      frame(8'(m) ^ 8'h01, 2, "R3"); drain("R3");
    end

    // R7: one-byte frame
    cfg(1, 8'h77);
    step(1, 8'h77, 1, 1, 0, 1, 0, 0, 0, "R7"); drain("R7");

    // R6: write coinciding with the address byte uses old value
    step(1, 8'h77, 1, 0, 0, 1, 1, 1, 8'h10, "R6");
    step(1, 8'hC0, 0, 0, 0, 1, 0, 0, 0, "R6");
    step(1, 8'hD1, 0, 1, 0, 1, 0, 0, 0, "R6"); drain("R6");
    frame(8'h77, 1, "R6"); drain("R6");
    frame(8'h10, 1, "R6"); drain("R6");
    // R6: disabled -> enabled on the address edge, then mid-frame rewrite
    cfg(0, 8'h10);
    step(1, 8'h33, 1, 0, 0, 1, 1, 1, 8'h10, "R6");
    step(1, 8'h34, 0, 0, 0, 1, 1, 1, 8'h99, "R6");
    step(1, 8'h35, 0, 1, 0, 1, 0, 0, 0, "R6"); drain("R6");
    frame(8'h33, 1, "R6"); drain("R6");
    frame(8'h99, 1, "R6"); drain("R6");

    // R8: abort with a byte of a kept frame, tail ignored
    cfg(1, 8'h21);
    step(1, 8'h21, 1, 0, 0, 1, 0, 0, 0, "R8");
    step(1, 8'h22, 0, 0, 0, 1, 0, 0, 0, "R8");
    step(1, 8'h23, 0, 0, 1, 1, 0, 0, 0, "R8");
    step(1, 8'h24, 0, 0, 0, 1, 0, 0, 0, "R8");
    step(1, 8'h25, 0, 1, 0, 1, 0, 0, 0, "R8"); drain("R8");
    // R8: abort on the end byte
    step(1, 8'h21, 1, 0, 0, 1, 0, 0, 0, "R8");
    step(1, 8'h26, 0, 1, 1, 1, 0, 0, 0, "R8"); drain("R8");
    // R8: receiver disable mid-frame and while a start arrives
    step(1, 8'h21, 1, 0, 0, 1, 0, 0, 0, "R8");
    step(1, 8'h27, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 8'h28, 0, 1, 0, 1, 0, 0, 0, "R8");
    step(1, 8'h21, 1, 1, 0, 0, 0, 0, 0, "R8"); drain("R8");

    // R9: stray bytes while idle
    step(1, 8'h21, 0, 0, 0, 1, 0, 0, 0, "R9");
    step(1, 8'h21, 0, 1, 0, 1, 0, 0, 0, "R9"); drain("R9");

    // R10: gaps inside a kept frame
    step(1, 8'h21, 1, 0, 0, 1, 0, 0, 0, "R10");
    idle(3);
    step(1, 8'hA0, 0, 0, 0, 1, 0, 0, 0, "R10");
    idle(1);
    step(1, 8'hA1, 0, 1, 0, 1, 0, 0, 0, "R10"); drain("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule